// File: doc/BRIEF.md
# Programmable-Order Sinc Decimator

This block converts a one-bit pulse-density stream into signed 24-bit PCM words using a cascade of integrators and combs (a sinc filter). Every accepted input bit counts as +1 when high and as -1 when low. A single instance handles one microphone channel. An input strobe marks each valid bit, and the output strobe fires once per decimation window.

The filter order (1 to 5) and the decimation ratio (a power of two from 8 to 256) are chosen at run time. Both settings are captured only when the channel starts, which is the rising edge of `run`. Edits made while the channel runs wait for the next start. The full-precision result is rescaled so that a stream of all ones lands on the largest positive 24-bit code. Words that come out before the comb history has filled are dropped.

Top module: `sinc_decim`

## Requirements
- R1: After synchronous reset, `pcm_valid` is low and `pcm_data` is zero.
- R2: A low input bit counts as -1. A stream of all zeros settles to the most negative code, 0x800000.
- R3: A stream of all ones gives +R^N at full precision. This saturates to the top code 0x7FFFFF and never wraps to a negative value.
- R4: A settled output equals 2^23 times (ones - zeros) / R over the window. A repeating 1110 stream gives 0x400000, a repeating 1000 stream gives 0xC00000, and an alternating stream gives 0.
- R5: The order is selected with `cfg_order` values 1 to 5, and the gain scales as order times log2(R).
- R6: After each start, the first N decimated words (N = the latched order) are discarded. A run of S strobes therefore yields floor(S/R) - N words when that count is positive, and none otherwise.
- R7: `cfg_ratio` codes 1 to 6 select R = 8, 16, 32, 64, 128 and 256. Exactly one word is produced per R accepted strobes.
- R8: `cfg_ratio` codes 0 and 7 to 15 disable the filter, and no `pcm_valid` pulse appears during that run.
- R9: The latched order is 3 after reset. A start with `cfg_order` outside 1 to 5 keeps the order latched previously.
- R10: Changing `cfg_order` or `cfg_ratio` while `run` is high has no effect until the next rising edge of `run`.
- R11: Strobes while `run` is low are ignored and produce no output. Each start clears all filter history and the window phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Channel active; a rising edge latches config and clears state |
| pdm_stb | input | 1 | Marks a valid input bit |
| pdm_bit | input | 1 | One-bit density sample |
| cfg_order | input | 4 | Requested filter order |
| cfg_ratio | input | 4 | Decimation ratio code |
| pcm_data | output | 24 | Signed output word |
| pcm_valid | output | 1 | One-cycle pulse per output word |

## Verification
The assertions assume that `pdm_stb` pulses are spaced at least three cycles apart. This lets each decimated value leave the comb and scaling registers before the next window closes. They also assume that the first strobe comes at least one cycle after `run` rises. The stimulus places strobes four cycles apart, waits two cycles after raising `run`, and lowers `run` only after the pipeline has drained. Configuration edits are made in the middle of a run to show that they are ignored.

// File: rtl/sinc_pkg.sv
package sinc_pkg;
  // Maps a ratio code to log2 of the decimation ratio; 0 means disabled.
  function automatic int unsigned ratio_log2(input logic [3:0] code, input int unsigned max_log2);
    int unsigned l;
    l = int'(code) + 2;
    if (code == 4'd0 || l > max_log2) return 0;
    return l;
  endfunction

  function automatic logic order_ok(input logic [3:0] ord, input int unsigned max_order);
    return (ord != 4'd0) && (int'(ord) <= max_order);
  endfunction
endpackage

// File: rtl/sinc_integ.sv
module sinc_integ #(
  parameter int ACC_W     = 42,
  parameter int MAX_ORDER = 5,
  parameter int OW        = $clog2(MAX_ORDER + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clr,
  input  logic                    en,
  input  logic                    din,
  input  logic [OW-1:0]           order,
  output logic signed [ACC_W-1:0] tap
);
  logic signed [ACC_W-1:0] acc [MAX_ORDER];
  logic signed [ACC_W-1:0] nxt [MAX_ORDER];
  logic signed [ACC_W-1:0] step;

  assign step = din ? ACC_W'(1) : {ACC_W{1'b1}};

  always_comb begin
    nxt[0] = acc[0] + step;
    for (int k = 1; k < MAX_ORDER; k++) nxt[k] = acc[k] + nxt[k-1];
  end

  assign tap = nxt[order - OW'(1)];

  generate
    for (genvar g = 0; g < MAX_ORDER; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst || clr) acc[g] <= '0;
        else if (en && (g < int'(order))) acc[g] <= nxt[g];
      end
    end
  endgenerate

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (!en && !clr) |=> $stable(acc[0]));
endmodule

// File: rtl/sinc_comb.sv
module sinc_comb #(
  parameter int ACC_W     = 42,
  parameter int MAX_ORDER = 5,
  parameter int OW        = $clog2(MAX_ORDER + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clr,
  input  logic                    go,
  input  logic signed [ACC_W-1:0] din,
  input  logic [OW-1:0]           order,
  output logic signed [ACC_W-1:0] dout,
  output logic                    dout_go
);
  logic signed [ACC_W-1:0] dly [MAX_ORDER];
  logic signed [ACC_W-1:0] dif [MAX_ORDER];
  logic [OW-1:0]           skip_cnt;

  always_comb begin
    dif[0] = din - dly[0];
    for (int k = 1; k < MAX_ORDER; k++) dif[k] = dif[k-1] - dly[k];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      for (int k = 0; k < MAX_ORDER; k++) dly[k] <= '0;
      skip_cnt <= '0;
      dout_go  <= 1'b0;
      dout     <= '0;
    end else begin
      dout_go <= 1'b0;
      if (go) begin
        dly[0] <= din;
        for (int k = 1; k < MAX_ORDER; k++)
          if (k < int'(order)) dly[k] <= dif[k-1];
        dout <= dif[order - OW'(1)];
        if (skip_cnt == order) dout_go <= 1'b1;
        else skip_cnt <= skip_cnt + OW'(1);
      end
    end
  end

  // R6: a word leaves only once the skip counter has reached the order.
  assert_skip_first_R6: assert property (@(posedge clk) disable iff (rst)
    dout_go |-> (skip_cnt == order));
endmodule

// File: rtl/sinc_scale.sv
module sinc_scale #(
  parameter int ACC_W = 42,
  parameter int OUT_W = 24,
  parameter int GW    = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    go,
  input  logic                    keep,
  input  logic signed [ACC_W-1:0] din,
  input  logic [GW-1:0]           gain,
  output logic [OUT_W-1:0]        dout,
  output logic                    dout_vld
);
  localparam int WIDE_W = ACC_W + OUT_W - 1;
  localparam logic signed [WIDE_W-1:0] POS_MAX =
    {{(WIDE_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [WIDE_W-1:0] NEG_MIN =
    {{(WIDE_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

  logic signed [WIDE_W-1:0] wide;
  logic [OUT_W-1:0]         sat;

  assign wide = $signed({din, {(OUT_W-1){1'b0}}}) >>> gain;

  always_comb begin
    if (wide > POS_MAX)      sat = {1'b0, {(OUT_W-1){1'b1}}};
    else if (wide < NEG_MIN) sat = {1'b1, {(OUT_W-1){1'b0}}};
    else                     sat = wide[OUT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout     <= '0;
      dout_vld <= 1'b0;
    end else begin
      dout_vld <= go && keep;
      if (go) dout <= sat;
    end
  end

  assert_no_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    (go && !din[ACC_W-1]) |=> !dout[OUT_W-1]);
endmodule

// File: rtl/sinc_decim.sv
module sinc_decim #(
  parameter int OUT_W     = 24,
  parameter int MAX_ORDER = 5,
  parameter int MAX_LOG2  = 8,
  parameter int CODE_W    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              pdm_stb,
  input  logic              pdm_bit,
  input  logic [CODE_W-1:0] cfg_order,
  input  logic [CODE_W-1:0] cfg_ratio,
  output logic [OUT_W-1:0]  pcm_data,
  output logic              pcm_valid
);
  import sinc_pkg::*;

  localparam int ACC_W = MAX_ORDER * MAX_LOG2 + 2;
  localparam int OW    = $clog2(MAX_ORDER + 1);
  localparam int LW    = $clog2(MAX_LOG2 + 1);
  localparam int GW    = $clog2(MAX_ORDER * MAX_LOG2 + 1);
  localparam logic [OW-1:0] ORDER_RST = OW'(3);

  logic                    run_q, start, clr, en;
  logic [OW-1:0]           order_q;
  logic [LW-1:0]           log_q;
  logic [MAX_LOG2-1:0]     phase, mask;
  logic                    dec_go, comb_go;
  logic signed [ACC_W-1:0] tap, dec_val, comb_val;
  logic [GW-1:0]           gain;

  assign start = run && !run_q;
  assign clr   = start || !run;
  assign en    = run && run_q && pdm_stb && (log_q != '0);
  assign mask  = ~({MAX_LOG2{1'b1}} << log_q);
  assign gain  = GW'(order_q) * GW'(log_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= 1'b0;
      order_q <= ORDER_RST;
      log_q   <= '0;
      phase   <= '0;
      dec_go  <= 1'b0;
      dec_val <= '0;
    end else begin
      run_q  <= run;
      dec_go <= 1'b0;
      if (start) begin
        if (order_ok(4'(cfg_order), MAX_ORDER)) order_q <= OW'(cfg_order);
        log_q <= LW'(ratio_log2(4'(cfg_ratio), MAX_LOG2));
      end
      if (clr) begin
        phase <= '0;
      end else if (en) begin
        if (phase == mask) begin
          phase   <= '0;
          dec_go  <= 1'b1;
          dec_val <= tap;
        end else begin
          phase <= phase + MAX_LOG2'(1);
        end
      end
    end
  end

  sinc_integ #(.ACC_W(ACC_W), .MAX_ORDER(MAX_ORDER), .OW(OW)) u_integ (
    .clk(clk), .rst(rst), .clr(clr), .en(en), .din(pdm_bit),
    .order(order_q), .tap(tap));

  sinc_comb #(.ACC_W(ACC_W), .MAX_ORDER(MAX_ORDER), .OW(OW)) u_comb (
    .clk(clk), .rst(rst), .clr(clr), .go(dec_go && !clr), .din(dec_val),
    .order(order_q), .dout(comb_val), .dout_go(comb_go));

  sinc_scale #(.ACC_W(ACC_W), .OUT_W(OUT_W), .GW(GW)) u_scale (
    .clk(clk), .rst(rst), .go(comb_go), .keep(run), .din(comb_val),
    .gain(gain), .dout(pcm_data), .dout_vld(pcm_valid));

  assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (run_q && run) |=> ($stable(order_q) && $stable(log_q)));

  assert_disabled_silent_R8: assert property (@(posedge clk) disable iff (rst)
    (log_q == '0) |-> !pcm_valid);

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    !run |=> !pcm_valid);

  assert_order_legal_R9: assert property (@(posedge clk) disable iff (rst)
    (order_q >= OW'(1)) && (int'(order_q) <= MAX_ORDER));
endmodule

// File: tb/sim_sinc_decim.sv
module sim_sinc_decim;
  logic        clk = 1'b0;
  logic        rst, run, pdm_stb, pdm_bit;
  logic [3:0]  cfg_order, cfg_ratio;
  logic [23:0] pcm_data;
  logic        pcm_valid;

  int checks = 0, fails = 0, seen = 0;
  logic  done = 1'b0;
  string cur_tag = "R1";
  logic [23:0] q_val[$];

  always #5 clk = ~clk;

  sinc_decim u0 (
    .clk(clk), .rst(rst), .run(run), .pdm_stb(pdm_stb), .pdm_bit(pdm_bit),
    .cfg_order(cfg_order), .cfg_ratio(cfg_ratio),
    .pcm_data(pcm_data), .pcm_valid(pcm_valid));

  // Monitor: pops the scoreboard on each output word.
  always @(negedge clk) begin
    if (!rst && pcm_valid) begin
      seen++;
      checks++;
      if (q_val.size() == 0) begin
        fails++;
        $display("FAIL %s: unexpected word actual=%h expected=none", cur_tag, pcm_data);
      end else begin
        logic [23:0] e;
        e = q_val.pop_front();
        if (pcm_data !== e) begin
          fails++;
          $display("FAIL %s: data actual=%h expected=%h", cur_tag, pcm_data, e);
        end
      end
    end
  end

  function automatic logic pat_bit(input int pat, input int i);
    case (pat)
      0: return 1'b1;
      1: return 1'b0;
      2: return (i % 2) == 0;
      3: return (i % 4) != 3;
      default: return (i % 4) == 0;
    endcase
  endfunction

  // Driver: pushes expected words, then feeds one run of strobes.
  task automatic run_case(input string tag, input logic [3:0] ord, input logic [3:0] code,
                          input int pat, input int nstb, input int exp_cnt,
                          input logic [23:0] exp_val, input logic do_chg,
                          input logic [3:0] chg_ord, input logic [3:0] chg_code);
    cur_tag = tag;
    seen = 0;
    for (int i = 0; i < exp_cnt; i++) q_val.push_back(exp_val);
    @(negedge clk);
    cfg_order = ord;
    cfg_ratio = code;
    run = 1'b1;
    repeat (2) @(negedge clk);
    for (int i = 0; i < nstb; i++) begin
      if (do_chg && i == nstb / 2) begin
        cfg_order = chg_ord;
        cfg_ratio = chg_code;
      end
      pdm_bit = pat_bit(pat, i);
      pdm_stb = 1'b1;
      @(negedge clk);
      pdm_stb = 1'b0;
      repeat (3) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    run = 1'b0;
    repeat (3) @(negedge clk);
    checks++;
    if (seen != exp_cnt || q_val.size() != 0) begin
      fails++;
      $display("FAIL %s: word count actual=%0d expected=%0d", tag, seen, exp_cnt);
      q_val.delete();
    end
  endtask

  task automatic finish_up;
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not finish actual=timeout expected=done");
    finish_up();
  end

  initial begin
    rst = 1'b1; run = 1'b0; pdm_stb = 1'b0; pdm_bit = 1'b0;
    cfg_order = 4'd0; cfg_ratio = 4'd0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    checks++;
    if (pcm_valid !== 1'b0 || pcm_data !== 24'h0) begin
      fails++;
      $display("FAIL R1: reset actual=%b/%h expected=0/000000", pcm_valid, pcm_data);
    end
    // R9: order 0 requested after reset -> default order 3, R=8: 5 windows - 3
    run_case("R9", 4'd0, 4'd1, 0, 40, 2, 24'h7FFFFF, 1'b0, 4'd0, 4'd0);
    // R2/R7: zeros, order 1, R=16: 10 windows - 1
    run_case("R2", 4'd1, 4'd2, 1, 160, 9, 24'h800000, 1'b0, 4'd0, 4'd0);
    // R3: ones, order 5, R=256: 7 windows - 5, saturates at the top code
    run_case("R3", 4'd5, 4'd6, 0, 1792, 2, 24'h7FFFFF, 1'b0, 4'd0, 4'd0);
    // R4: 1110 stream, order 2, R=32
    run_case("R4", 4'd2, 4'd3, 3, 320, 8, 24'h400000, 1'b0, 4'd0, 4'd0);
    // R4: alternating stream, order 4, R=64
    run_case("R4", 4'd4, 4'd4, 2, 512, 4, 24'h000000, 1'b0, 4'd0, 4'd0);
    // R5: 1000 stream, order 5, R=8
    run_case("R5", 4'd5, 4'd1, 4, 96, 7, 24'hC00000, 1'b0, 4'd0, 4'd0);
    // R9: illegal order 7 keeps order 5, R=128
    run_case("R9", 4'd7, 4'd5, 0, 896, 2, 24'h7FFFFF, 1'b0, 4'd0, 4'd0);
    // R8: disabled codes
    run_case("R8", 4'd2, 4'd0, 0, 200, 0, 24'h0, 1'b0, 4'd0, 4'd0);
    run_case("R8", 4'd2, 4'd11, 0, 200, 0, 24'h0, 1'b0, 4'd0, 4'd0);
    // R10: mid-run edit to order 5 / R=256 is ignored; stays order 2, R=16
    run_case("R10", 4'd2, 4'd2, 0, 160, 8, 24'h7FFFFF, 1'b1, 4'd5, 4'd6);
    // R11: strobes with run low
    cur_tag = "R11";
    seen = 0;
    cfg_order = 4'd1; cfg_ratio = 4'd1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk); pdm_bit = 1'b1; pdm_stb = 1'b1;
      @(negedge clk); pdm_stb = 1'b0;
    end
    repeat (4) @(negedge clk);
    checks++;
    if (seen != 0) begin
      fails++;
      $display("FAIL R11: idle words actual=%0d expected=0", seen);
    end
    // R6: order 3, R=16: 3 windows all discarded, then 4 windows give 1
    run_case("R6", 4'd3, 4'd2, 0, 48, 0, 24'h0, 1'b0, 4'd0, 4'd0);
    run_case("R6", 4'd3, 4'd2, 1, 64, 1, 24'h800000, 1'b0, 4'd0, 4'd0);
    // R11: restart after a partial run starts from clean history and phase
    run_case("R11", 4'd2, 4'd1, 3, 28, 1, 24'h400000, 1'b0, 4'd0, 4'd0);
    run_case("R11", 4'd2, 4'd1, 4, 40, 3, 24'hC00000, 1'b0, 4'd0, 4'd0);
    finish_up();
  end
endmodule